// File: doc/BRIEF.md
# Loadable Modulo Counter with Range Control

This block is a synchronous up-counter built from a base cell that counts modulo N. The cell has a synchronous clear, a parallel load and a count enable, and it raises a terminal-count flag. The flag is high only while counting is enabled and the cell sits in its last state. Clear beats load, and load beats count. A compile-time mode parameter selects one of four arrangements:

- **Full mode:** the bare mod-N counter.
- **Short mode:** the counter wraps to zero after state M-1.
- **Range mode:** the counter wraps back to A after state B.
- **Chain mode:** two cells are joined through the terminal count into one counter of twice the width that runs modulo N*N.

The short and range modes are built only from reload logic outside the base cell. When counting is enabled and the wrap state is reached, that logic asserts a load of the restart value. In range mode the user is expected to start the count from A, for example by loading A after a clear. Any state outside A..B simply follows the mod-N cell behaviour.

Top module: `ctr_range_top`

## Requirements
- R1: When `rst` is 0 and `clr` is 1, `q` is all zeros after the next clock edge, whatever `ld`, `cnt` and `d` are.
- R2: When `clr` is 0 and `ld` is 1, `q` takes the value of `d` at the next edge, whatever `cnt` is.
- R3: When `clr`=0, `ld`=0 and `cnt`=1, and no wrap state applies, `q` becomes (`q`+1) mod N (mod N*N in chain mode).
- R4: When `clr`, `ld` and `cnt` are all 0, `q` keeps its value.
- R5: `tc` is 1 exactly when `cnt` is 1 and `q` equals the mode's last state: N-1 in full mode, M-1 in short mode, B in range mode, N*N-1 in chain mode.
- R6: In short mode, with `clr`=0, `ld`=0, `cnt`=1 and `q`=M-1, the next `q` is 0.
- R7: In range mode, with `clr`=0, `ld`=0, `cnt`=1 and `q`=B, the next `q` is A.
- R8: In chain mode, the upper half of `q` (bits 2*log2(N)-1 down to log2(N)) changes on a counting step only when the lower half is N-1. The whole counter runs modulo N*N.
- R9: A synchronous `rst`=1 gives `q`=0 after the next edge.
- R10: In short and range modes, an external load in a cycle where the wrap condition holds takes `d`, not the restart value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear, highest priority |
| ld | input | 1 | Parallel load of `d` |
| cnt | input | 1 | Count enable |
| d | input | OW | Load value; OW is log2(N), or twice that in chain mode |
| q | output | OW | Counter state |
| tc | output | 1 | Terminal count of the selected mode |

## Verification
All four mode variants are driven with the same input stream and compared each cycle against a behavioural model. The stream includes long uninterrupted counting runs, which separate the wrap points of the four modes (N-1, M-1, B and N*N-1) and show the carry into the upper half in chain mode. Stretches with mixed clear, load and enable show whether the priority order is kept and whether a held count stays put. Loads of values outside the A..B range and loads issued exactly on a wrap state show whether the external load overrides the restart value.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

    typedef enum logic [1:0] {
        MODE_FULL  = 2'd0,
        MODE_SHORT = 2'd1,
        MODE_RANGE = 2'd2,
        MODE_CHAIN = 2'd3
    } mode_e;

    typedef struct packed {
        logic clr;
        logic ld;
        logic cnt;
    } ctl_t;

    // State at which the selected mode wraps or flags terminal count
    function automatic int unsigned last_state(mode_e mode, int unsigned n,
                                               int unsigned m, int unsigned b);
        case (mode)
            MODE_SHORT: return m - 1;
            MODE_RANGE: return b;
            default:    return n - 1;
        endcase
    endfunction

    // Value reloaded when the wrap state is reached
    function automatic int unsigned restart_value(mode_e mode, int unsigned a);
        return (mode == MODE_RANGE) ? a : 0;
    endfunction

endpackage

// File: rtl/ctr_cell.sv
module ctr_cell #(
    parameter int unsigned N  = 16,
    parameter int unsigned CW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst,
    input  ctr_pkg::ctl_t   ctl,
    input  logic [CW-1:0]   d,
    output logic [CW-1:0]   q,
    output logic            tc
);
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    always_ff @(posedge clk) begin
        if (rst)            q <= '0;
        else if (ctl.clr)   q <= '0;
        else if (ctl.ld)    q <= d;
        else if (ctl.cnt)   q <= (q == LAST) ? '0 : q + CW'(1);
    end

    assign tc = ctl.cnt && (q == LAST);

    // R1
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.clr |=> (q == '0));
    // R2
    load_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl.clr && ctl.ld) |=> (q == $past(d)));
    // R3
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl.clr && !ctl.ld && ctl.cnt && q != LAST) |=> (q == $past(q) + CW'(1)));
    // R4
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl.clr && !ctl.ld && !ctl.cnt) |=> $stable(q));
endmodule

// File: rtl/ctr_wrap.sv
module ctr_wrap #(
    parameter ctr_pkg::mode_e MODE = ctr_pkg::MODE_SHORT,
    parameter int unsigned N  = 16,
    parameter int unsigned M  = 6,
    parameter int unsigned A  = 5,
    parameter int unsigned B  = 11,
    parameter int unsigned CW = $clog2(N)
) (
    input  logic [CW-1:0]   q,
    input  logic            cnt,
    input  logic            ld,
    input  logic [CW-1:0]   d,
    output logic            eff_ld,
    output logic [CW-1:0]   eff_d,
    output logic            hit
);
    localparam logic [CW-1:0] LAST    = CW'(ctr_pkg::last_state(MODE, N, M, B));
    localparam logic [CW-1:0] RESTART = CW'(ctr_pkg::restart_value(MODE, A));
    localparam logic          WRAP_EN = (MODE == ctr_pkg::MODE_SHORT) ||
                                        (MODE == ctr_pkg::MODE_RANGE);

    always_comb begin
        hit    = cnt && (q == LAST);
        eff_ld = ld || (WRAP_EN && hit);
        eff_d  = ld ? d : RESTART;
    end
endmodule

// File: rtl/ctr_range_top.sv
module ctr_range_top #(
    parameter ctr_pkg::mode_e MODE = ctr_pkg::MODE_SHORT,
    parameter int unsigned N = 16,
    parameter int unsigned M = 6,
    parameter int unsigned A = 5,
    parameter int unsigned B = 11,
    localparam int unsigned CW = $clog2(N),
    localparam int unsigned OW = (MODE == ctr_pkg::MODE_CHAIN) ? 2 * CW : CW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          ld,
    input  logic          cnt,
    input  logic [OW-1:0] d,
    output logic [OW-1:0] q,
    output logic          tc
);
    import ctr_pkg::*;

    generate
        if (MODE == MODE_CHAIN) begin : g_chain
            ctl_t          lo_ctl, hi_ctl;
            logic [CW-1:0] lo_q, hi_q;
            logic          lo_tc, hi_tc;

            assign lo_ctl = '{clr: clr, ld: ld, cnt: cnt};
            assign hi_ctl = '{clr: clr, ld: ld, cnt: lo_tc};

            ctr_cell #(.N(N), .CW(CW)) u_lo (
                .clk(clk), .rst(rst), .ctl(lo_ctl), .d(d[CW-1:0]),
                .q(lo_q), .tc(lo_tc));
            ctr_cell #(.N(N), .CW(CW)) u_hi (
                .clk(clk), .rst(rst), .ctl(hi_ctl), .d(d[OW-1:CW]),
                .q(hi_q), .tc(hi_tc));

            assign q  = {hi_q, lo_q};
            assign tc = hi_tc;

            // R8
            upper_hold_chk: assert property (@(posedge clk) disable iff (rst)
                (!clr && !ld && !(cnt && q[CW-1:0] == CW'(N - 1)))
                    |=> $stable(q[OW-1:CW]));
        end else begin : g_single
            ctl_t          c_ctl;
            logic [CW-1:0] c_d;
            logic          c_ld, c_tc, w_hit;

            ctr_wrap #(.MODE(MODE), .N(N), .M(M), .A(A), .B(B), .CW(CW)) u_wrap (
                .q(q), .cnt(cnt), .ld(ld), .d(d),
                .eff_ld(c_ld), .eff_d(c_d), .hit(w_hit));

            assign c_ctl = '{clr: clr, ld: c_ld, cnt: cnt};

            ctr_cell #(.N(N), .CW(CW)) u_cell (
                .clk(clk), .rst(rst), .ctl(c_ctl), .d(c_d),
                .q(q), .tc(c_tc));

            assign tc = (MODE == MODE_FULL) ? c_tc : w_hit;

            if (MODE == MODE_SHORT) begin : g_short_chk
                // R6
                short_wrap_chk: assert property (@(posedge clk) disable iff (rst)
                    (tc && !clr && !ld) |=> (q == '0));
            end
            if (MODE == MODE_RANGE) begin : g_range_chk
                // R7
                range_wrap_chk: assert property (@(posedge clk) disable iff (rst)
                    (tc && !clr && !ld) |=> (q == CW'(A)));
            end
            // R10
            load_over_wrap_chk: assert property (@(posedge clk) disable iff (rst)
                (tc && !clr && ld) |=> (q == $past(d)));
        end
    endgenerate

    // R9
    reset_chk: assert property (@(posedge clk) rst |=> (q == '0));
endmodule

// File: tb/tb_ctr_range_top.sv
module tb_ctr_range_top;
    import ctr_pkg::*;

    localparam int N = 16, M = 6, A = 5, B = 11;

    logic clk = 0, rst = 1, clr = 0, ld = 0, cnt = 0;
    logic [7:0] d_in = '0;
    logic [3:0] qf, qs, qr;
    logic [7:0] qc;
    logic tcf, tcs, tcr, tcc;

    always #5 clk = ~clk;

    ctr_range_top #(.MODE(MODE_FULL),  .N(N), .M(M), .A(A), .B(B)) dut (
        .clk(clk), .rst(rst), .clr(clr), .ld(ld), .cnt(cnt), .d(d_in[3:0]), .q(qf), .tc(tcf));
    ctr_range_top #(.MODE(MODE_SHORT), .N(N), .M(M), .A(A), .B(B)) dut_short (
        .clk(clk), .rst(rst), .clr(clr), .ld(ld), .cnt(cnt), .d(d_in[3:0]), .q(qs), .tc(tcs));
    ctr_range_top #(.MODE(MODE_RANGE), .N(N), .M(M), .A(A), .B(B)) dut_range (
        .clk(clk), .rst(rst), .clr(clr), .ld(ld), .cnt(cnt), .d(d_in[3:0]), .q(qr), .tc(tcr));
    ctr_range_top #(.MODE(MODE_CHAIN), .N(N), .M(M), .A(A), .B(B)) dut_chain (
        .clk(clk), .rst(rst), .clr(clr), .ld(ld), .cnt(cnt), .d(d_in), .q(qc), .tc(tcc));

    int compared = 0, mismatched = 0;
    int mf = 0, ms = 0, mr = 0, mc = 0;
    string tf = "R9", ts = "R9", tr = "R9", tc_tag = "R9";

    // Behavioural reference: next state of each mode
    always @(posedge clk) begin
        if (rst) begin
            mf <= 0; ms <= 0; mr <= 0; mc <= 0;
            tf <= "R9"; ts <= "R9"; tr <= "R9"; tc_tag <= "R9";
        end else if (clr) begin
            mf <= 0; ms <= 0; mr <= 0; mc <= 0;
            tf <= "R1"; ts <= "R1"; tr <= "R1"; tc_tag <= "R1";
        end else if (ld) begin
            mf <= d_in % N; ms <= d_in % N; mr <= d_in % N; mc <= d_in;
            tf <= "R2";
            ts <= (cnt && ms == M - 1) ? "R10" : "R2";
            tr <= (cnt && mr == B) ? "R10" : "R2";
            tc_tag <= "R2";
        end else if (cnt) begin
            mf <= (mf + 1) % N; tf <= "R3";
            if (ms == M - 1) begin ms <= 0; ts <= "R6"; end
            else begin ms <= (ms + 1) % N; ts <= "R3"; end
            if (mr == B) begin mr <= A; tr <= "R7"; end
            else begin mr <= (mr + 1) % N; tr <= "R3"; end
            mc <= (mc + 1) % (N * N); tc_tag <= "R8";
        end else begin
            tf <= "R4"; ts <= "R4"; tr <= "R4"; tc_tag <= "R4";
        end
    end

    task automatic chk(string tag, string what, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic step(logic c, logic l, logic e, logic [7:0] dv);
        @(negedge clk);
        clr = c; ld = l; cnt = e; d_in = dv;
        #1;
        chk(tf, "full q", int'(qf), mf);
        chk(ts, "short q", int'(qs), ms);
        chk(tr, "range q", int'(qr), mr);
        chk(tc_tag, "chain q", int'(qc), mc);
        chk("R5", "full tc", int'(tcf), int'(e && mf == N - 1));
        chk("R5", "short tc", int'(tcs), int'(e && ms == M - 1));
        chk("R5", "range tc", int'(tcr), int'(e && mr == B));
        chk("R5", "chain tc", int'(tcc), int'(e && mc == N * N - 1));
    endtask

    initial begin
        #2000000;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst = 1;
        step(0, 0, 0, 8'h00);          // R9 reset state
        @(negedge clk); rst = 0;
        for (int i = 0; i < 5; i++) step(0, 0, 1, 8'h00);
        step(0, 1, 1, 8'h03);          // R10 load on short wrap state
        step(0, 0, 0, 8'hFF);          // R4 hold
        step(1, 1, 1, 8'hAA);          // R1 clear dominates
        step(0, 1, 0, 8'h05);          // R2 load start of range
        for (int i = 0; i < 300; i++) step(0, 0, 1, 8'h00);   // R3 R6 R7 R8 runs
        step(0, 1, 1, 8'h0B);          // load 11
        step(0, 1, 1, 8'h0D);          // R10 range: load while at B
        for (int i = 0; i < 6; i++) step(0, 0, 1, 8'h00);
        step(0, 1, 0, 8'hEF);          // chain near top
        for (int i = 0; i < 20; i++) step(0, 0, 1, 8'h00);
        for (int i = 0; i < 8; i++) step(0, 0, 0, 8'h33);    // R4 hold
        for (int i = 0; i < 400; i++) begin
            logic [7:0] r;
            r = 8'($urandom);
            step(r[7:5] == 3'd0, r[4:2] == 3'd0, r[1] | r[0], 8'($urandom));
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule